// File: doc/BRIEF.md
# Programmable Chip Select Generator

This block turns a 32-bit bus address into one of four active-low select lines. It also times the end of each bus cycle that it decodes. Each channel holds a base address and a don't-care mask, so its block size is a power of two from 256 bytes up to the full 4 GB space. Each channel also holds a set of allowed address spaces (one enable bit per value of a 3-bit space code), a write-protect flag, a port-width flag (8 or 16 bit) and a termination setting. A bus cycle starts when the bus master raises `busStrobe`. The master holds the address, space and direction stable until it sees `busDone` or `busErr`, and then drops the strobe.

A channel ends the cycle by one of three methods: fast termination, one to three inserted wait states, or the external acknowledge input. When a write hits a write-protected channel, the block asserts no select and flags a bus error instead. When several channels match, the lowest-numbered one wins. A simple register write port loads the channel settings. Out of reset, channel 0 covers the whole address space as slow 8-bit memory, so the processor can boot from a narrow ROM.

Top module: `cs_gen_top`

## Requirements
- R1: While `busStrobe` is low, `csN` is all ones. While it is high, the winning channel's bit of `csN` is 0 and every other bit is 1.
- R2: A channel matches when address bits 31:8 equal its base on every bit where its mask bit is 0. Mask bits set to 1 are don't care, and address bits 7:0 never take part in the compare.
- R3: A channel matches only if bit `busSpace` of its 8-bit space-enable field is 1.
- R4: A write that hits a write-protected winning channel asserts no select and no `busDone`. It raises `busErr` for exactly one cycle, in the cycle after the first clock edge that sees the strobe. Reads of that channel complete normally.
- R5: A channel with its enable bit at 0 never matches. Among the enabled channels that match, the lowest index wins.
- R6: With internal timing and wait count N (0 to 3), `busDone` is a one-cycle pulse in the cycle after the (N+1)-th clock edge that sees the strobe high. N = 0 is fast termination.
- R7: With external termination selected, the wait count is ignored. `busDone` follows in the cycle after the first edge (the second edge of the bus cycle or later) at which `extAck` is sampled high. Without an acknowledge, the cycle does not end.
- R8: `portWide` is 1 during a selected cycle whose winning channel is set to 16 bit, and 0 otherwise.
- R9: After reset, channel 0 is enabled with base 0, mask all ones, all spaces enabled, 8-bit width, 3 wait states and no write protection. Channels 1 to 3 are disabled.
- R10: A pulse on `cfgWe` loads word `cfgSel` of channel `cfgChan` from `cfgData`. Word 0 is the base, word 1 the mask, and word 2 the options: bit 0 enable, bit 1 write protect, bit 2 16-bit width, bits 4:3 wait count, bit 5 external termination, bits 15:8 space enables. A write with `cfgSel` = 3 changes nothing.
- R11: A bus cycle that matches no channel produces neither `busDone` nor `busErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgChan | input | 2 | Channel to configure |
| cfgSel | input | 2 | Word select: base, mask, options |
| cfgData | input | 32 | Configuration write data |
| busStrobe | input | 1 | Bus cycle active, held until termination |
| busAddr | input | 32 | Bus address |
| busSpace | input | 3 | Address-space code |
| busWrite | input | 1 | 1 for a write cycle |
| extAck | input | 1 | External termination acknowledge |
| csN | output | 4 | Active-low chip selects |
| busDone | output | 1 | Cycle termination pulse |
| busErr | output | 1 | Write-protect violation pulse |
| portWide | output | 1 | Selected port is 16 bits wide |

## Verification
The assertions assume the bus master holds address, space and direction unchanged for as long as the strobe is high. They also assume the master drops the strobe only after it sees a termination or error, and does not write the configuration during a bus cycle. The bench's cycle task drives all bus inputs at a falling edge and releases the strobe only after the response or a timeout. It performs every configuration write with the strobe low.

// File: rtl/cs_gen_pkg.sv
package cs_gen_pkg;
  localparam int ADDR_W   = 32;
  localparam int SPACE_W  = 3;
  localparam int SPACES   = 1 << SPACE_W;
  localparam int WAIT_W   = 2;
  localparam int BLK_BITS = 8;   // smallest block is 2**BLK_BITS bytes

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
    logic [SPACES-1:0] spaceEn;
    logic              extTerm;
    logic [WAIT_W-1:0] waits;
    logic              wide;
    logic              wrProt;
    logic              enable;
  } chanCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;   // capture winner's wait count, clear counter
    logic count;   // advance wait counter
  } ctrlStrobe_t;

  // decode status from datapath to control
  typedef struct packed {
    logic hit;
    logic protErr;
    logic extTerm;
    logic fast;
    logic lastWait;
  } dpStatus_t;

  typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_HOLD} busState_t;
endpackage

// File: rtl/cs_gen_datapath.sv
module cs_gen_datapath
  import cs_gen_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgChan,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              busStrobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SPACE_W-1:0] busSpace,
  input  logic              busWrite,
  input  ctrlStrobe_t       ctrl,
  output dpStatus_t         status,
  output logic [NUM_CH-1:0] csN,
  output logic              portWide
);
  chanCfg_t          cfgQ [NUM_CH];
  logic [NUM_CH-1:0] chMatch;
  logic [WAIT_W-1:0] waitQ, cntQ;
  logic              hit;
  logic [CH_W-1:0]   win;
  chanCfg_t          winCfg;

  // per-channel configuration registers and compare
  for (genvar g = 0; g < NUM_CH; g++) begin : gen_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ[g].base    <= '0;
        cfgQ[g].mask    <= (g == 0) ? '1 : '0;
        cfgQ[g].spaceEn <= (g == 0) ? '1 : '0;
        cfgQ[g].extTerm <= 1'b0;
        cfgQ[g].waits   <= (g == 0) ? '1 : '0;
        cfgQ[g].wide    <= 1'b0;
        cfgQ[g].wrProt  <= 1'b0;
        cfgQ[g].enable  <= (g == 0);
      end else if (cfgWe && cfgChan == CH_W'(g)) begin
        case (cfgSel)
          2'd0: cfgQ[g].base <= cfgData;
          2'd1: cfgQ[g].mask <= cfgData;
          2'd2: begin
            cfgQ[g].enable  <= cfgData[0];
            cfgQ[g].wrProt  <= cfgData[1];
            cfgQ[g].wide    <= cfgData[2];
            cfgQ[g].waits   <= cfgData[4:3];
            cfgQ[g].extTerm <= cfgData[5];
            cfgQ[g].spaceEn <= cfgData[8 +: SPACES];
          end
          default: ;
        endcase
      end
    end

    assign chMatch[g] = cfgQ[g].enable && cfgQ[g].spaceEn[busSpace] &&
      (((busAddr[ADDR_W-1:BLK_BITS] ^ cfgQ[g].base[ADDR_W-1:BLK_BITS]) &
        ~cfgQ[g].mask[ADDR_W-1:BLK_BITS]) == '0);
  end

  // lowest index wins
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chMatch[i]) begin
        hit = 1'b1;
        win = CH_W'(i);
      end
    end
  end

  assign winCfg = cfgQ[win];

  always_comb begin
    status.hit      = hit;
    status.protErr  = hit && winCfg.wrProt && busWrite;
    status.extTerm  = winCfg.extTerm;
    status.fast     = (winCfg.waits == '0);
    status.lastWait = ({1'b0, cntQ} + 1'b1) == {1'b0, waitQ};
  end

  always_comb begin
    csN = '1;
    if (busStrobe && hit && !status.protErr) csN[win] = 1'b0;
  end

  assign portWide = busStrobe && hit && !status.protErr && winCfg.wide;

  // wait-state counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitQ <= '0;
      cntQ  <= '0;
    end else if (ctrl.latch) begin
      waitQ <= winCfg.waits;
      cntQ  <= '0;
    end else if (ctrl.count) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assert_wide_sel_R8: assert property (@(posedge clk) disable iff (!rstN)
    portWide |-> (csN != '1));
  assert_one_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1);
endmodule

// File: rtl/cs_gen_control.sv
module cs_gen_control
  import cs_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busStrobe,
  input  logic        extAck,
  input  dpStatus_t   status,
  output ctrlStrobe_t ctrl,
  output logic        busDone,
  output logic        busErr
);
  busState_t stateQ, stateD;
  logic      extQ, extD, doneD, errD;

  always_comb begin
    stateD = stateQ;
    extD   = extQ;
    doneD  = 1'b0;
    errD   = 1'b0;
    ctrl   = '0;
    case (stateQ)
      ST_IDLE: if (busStrobe) begin
        if (status.protErr) begin
          errD   = 1'b1;
          stateD = ST_HOLD;
        end else if (status.hit) begin
          ctrl.latch = 1'b1;
          extD       = status.extTerm;
          if (status.extTerm) stateD = ST_COUNT;
          else if (status.fast) begin
            doneD  = 1'b1;
            stateD = ST_HOLD;
          end else stateD = ST_COUNT;
        end else begin
          stateD = ST_HOLD;   // not ours: wait for the strobe to drop
        end
      end
      ST_COUNT: begin
        if (!busStrobe) stateD = ST_IDLE;
        else if (extQ) begin
          if (extAck) begin
            doneD  = 1'b1;
            stateD = ST_HOLD;
          end
        end else if (status.lastWait) begin
          doneD  = 1'b1;
          stateD = ST_HOLD;
        end else ctrl.count = 1'b1;
      end
      default: if (!busStrobe) stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      extQ    <= 1'b0;
      busDone <= 1'b0;
      busErr  <= 1'b0;
    end else begin
      stateQ  <= stateD;
      extQ    <= extD;
      busDone <= doneD;
      busErr  <= errD;
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    busDone |=> !busDone);
  assert_done_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    busDone |-> $past(busStrobe));
  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> !busErr);
  assert_err_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(busDone && busErr));
endmodule

// File: rtl/cs_gen_top.sv
module cs_gen_top
  import cs_gen_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [1:0]         cfgChan,
  input  logic [1:0]         cfgSel,
  input  logic [31:0]        cfgData,
  input  logic               busStrobe,
  input  logic [31:0]        busAddr,
  input  logic [2:0]         busSpace,
  input  logic               busWrite,
  input  logic               extAck,
  output logic [NUM_CH-1:0]  csN,
  output logic               busDone,
  output logic               busErr,
  output logic               portWide
);
  ctrlStrobe_t ctrl;
  dpStatus_t   status;

  cs_gen_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgSel(cfgSel),
    .cfgData(cfgData), .busStrobe(busStrobe), .busAddr(busAddr),
    .busSpace(busSpace), .busWrite(busWrite), .ctrl(ctrl), .status(status),
    .csN(csN), .portWide(portWide)
  );

  cs_gen_control u_ctl (
    .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .extAck(extAck),
    .status(status), .ctrl(ctrl), .busDone(busDone), .busErr(busErr)
  );

  assert_sel_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busStrobe |-> (csN == '1));
  assert_err_nosel_R4: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (csN == '1) && !busDone);
endmodule

// File: tb/cs_gen_top_tb.sv
module cs_gen_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        cfgWe = 0, busStrobe = 0, busWrite = 0, extAck = 0;
  logic [1:0]  cfgChan = 0, cfgSel = 0;
  logic [31:0] cfgData = 0, busAddr = 0;
  logic [2:0]  busSpace = 0;
  logic [3:0]  csN;
  logic        busDone, busErr, portWide;
  int          checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_gen_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgSel(cfgSel),
    .cfgData(cfgData), .busStrobe(busStrobe), .busAddr(busAddr),
    .busSpace(busSpace), .busWrite(busWrite), .extAck(extAck), .csN(csN),
    .busDone(busDone), .busErr(busErr), .portWide(portWide)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic cfgWrite(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1; cfgChan = 2'(ch); cfgSel = 2'(sel); cfgData = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  // options word: en[0] prot[1] wide[2] waits[4:3] ext[5] spaces[15:8]
  function automatic logic [31:0] opts(input bit en, input bit prot, input bit wide,
                                       input int waits, input bit ext, input logic [7:0] sp);
    return {16'd0, sp, 2'b00, ext, 2'(waits), wide, prot, en};
  endfunction

  // lat = 0 means no termination within the window
  task automatic busCycle(input logic [31:0] a, input int sp, input bit wr, input int ackAt,
                          output logic [3:0] cs, output bit wide, output int lat, output bit err);
    @(negedge clk);
    busAddr = a; busSpace = 3'(sp); busWrite = wr; busStrobe = 1; extAck = 0;
    #1;
    cs = csN; wide = portWide; lat = 0; err = 0;
    for (int n = 1; n <= 10 && lat == 0 && !err; n++) begin
      @(negedge clk);
      if (busDone) lat = n;
      if (busErr) err = 1;
      if (lat == 0 && ackAt > 0 && n == ackAt) extAck = 1;
    end
    busStrobe = 0; extAck = 0;
    @(negedge clk);
  endtask

  task automatic expectCycle(input string req, input logic [31:0] a, input int sp, input bit wr,
                             input int ackAt, input logic [3:0] expCs, input bit expWide,
                             input int expLat, input bit expErr);
    logic [3:0] cs; bit wide; int lat; bit err;
    busCycle(a, sp, wr, ackAt, cs, wide, lat, err);
    check(req, $sformatf("csN @%h", a), cs, expCs);
    check(req, $sformatf("latency @%h", a), lat, expLat);
    check(req, $sformatf("busErr @%h", a), err, expErr);
    check(req, $sformatf("portWide @%h", a), wide, expWide);
  endtask

  task automatic testReset();
    check("R1", "idle csN", csN, 4'hF);
    check("R9", "idle done/err", {busDone, busErr}, 0);
    expectCycle("R9", 32'h1234_5678, 5, 0, 0, 4'b1110, 0, 4, 0);
    expectCycle("R9", 32'hFFFF_FF00, 0, 1, 0, 4'b1110, 0, 4, 0);
  endtask

  task automatic testDecode();
    cfgWrite(0, 0, 32'hFF00_0000);
    cfgWrite(0, 1, 32'h00FF_FFFF);
    cfgWrite(0, 2, opts(1, 0, 0, 2, 0, 8'hFF));
    cfgWrite(1, 0, 32'h0010_0000);
    cfgWrite(1, 1, 32'h000F_FFFF);
    cfgWrite(1, 2, opts(1, 0, 1, 0, 0, 8'hFF));
    expectCycle("R2", 32'h0010_0000, 1, 0, 0, 4'b1101, 1, 1, 0);
    expectCycle("R2", 32'h001F_FFFF, 2, 1, 0, 4'b1101, 1, 1, 0);
    expectCycle("R11", 32'h0020_0000, 1, 0, 0, 4'b1111, 0, 0, 0);
    expectCycle("R8", 32'hFF12_3400, 1, 0, 0, 4'b1110, 0, 3, 0);
  endtask

  task automatic testSmallBlock();
    cfgWrite(3, 0, 32'h0000_45A7);   // bits below 8 never compared
    cfgWrite(3, 1, 32'h0000_0000);
    cfgWrite(3, 2, opts(1, 0, 1, 1, 0, 8'b0010_0000));
    expectCycle("R2", 32'h0000_45FF, 5, 0, 0, 4'b0111, 1, 2, 0);
    expectCycle("R2", 32'h0000_4500, 5, 0, 0, 4'b0111, 1, 2, 0);
    expectCycle("R2", 32'h0000_4600, 5, 0, 0, 4'b1111, 0, 0, 0);
    expectCycle("R2", 32'h0000_44FF, 5, 0, 0, 4'b1111, 0, 0, 0);
    expectCycle("R3", 32'h0000_4510, 1, 0, 0, 4'b1111, 0, 0, 0);
  endtask

  task automatic testWaits();
    for (int w = 0; w < 4; w++) begin
      cfgWrite(3, 2, opts(1, 0, 0, w, 0, 8'hFF));
      expectCycle("R6", 32'h0000_4520, 3, 0, 0, 4'b0111, 0, w + 1, 0);
    end
  endtask

  task automatic testProtect();
    cfgWrite(1, 2, opts(1, 1, 1, 0, 0, 8'hFF));
    expectCycle("R4", 32'h0012_0000, 1, 0, 0, 4'b1101, 1, 1, 0);
    expectCycle("R4", 32'h0012_0000, 1, 1, 0, 4'b1111, 0, 0, 1);
    cfgWrite(1, 2, opts(1, 0, 1, 0, 0, 8'hFF));
  endtask

  task automatic testPriority();
    cfgWrite(2, 0, 32'h0000_0000);
    cfgWrite(2, 1, 32'h0FFF_FFFF);
    cfgWrite(2, 2, opts(1, 0, 0, 3, 1, 8'hFF));
    expectCycle("R5", 32'h0015_0000, 1, 0, 0, 4'b1101, 1, 1, 0);
    expectCycle("R5", 32'h0150_0000, 1, 0, 1, 4'b1011, 0, 2, 0);
    cfgWrite(1, 2, opts(0, 0, 1, 0, 0, 8'hFF));
    expectCycle("R5", 32'h0015_0000, 1, 0, 1, 4'b1011, 0, 2, 0);
  endtask

  task automatic testExternal();
    expectCycle("R7", 32'h0150_0000, 1, 0, 4, 4'b1011, 0, 5, 0);
    expectCycle("R7", 32'h0150_0000, 1, 1, 0, 4'b1011, 0, 0, 0);
  endtask

  task automatic testCfgIgnore();
    cfgWrite(2, 3, 32'hFFFF_FFFF);
    cfgWrite(0, 3, 32'h0000_0000);
    expectCycle("R10", 32'h0150_0000, 1, 0, 2, 4'b1011, 0, 3, 0);
    expectCycle("R10", 32'hFF00_0000, 1, 0, 0, 4'b1110, 0, 3, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testDecode();
    testSmallBlock();
    testWaits();
    testProtect();
    testPriority();
    testExternal();
    testCfgIgnore();
    summary();
  end
endmodule